// File: doc/BRIEF.md
# Mode-Programmable Handshaking Byte Port

A byte-wide parallel port. A static mode pin makes it either an input port, where a peripheral strobes a byte in and the port raises a request toward the processor, or an output port, where the processor strobes a byte in and the port raises a request toward the peripheral. It holds one data register. The register is transparent while its strobe is qualified and holds on the strobe's trailing edge. The port has two chip selects: one is active-high in both modes, and the other flips polarity with the mode. It has an asynchronous active-low clear and a single service-request output whose idle level depends on the mode. The three-state data bus is modelled as a data vector plus an enable flag.

Everything runs on one fast system clock. The strobe and both selects are external asynchronous pins. They pass through a synchronizer before any edge is detected. A change of the mode pin while running behaves like a clear.

Top module: `hs_byte_port`

## Requirements
- R1: `mode`=0 selects input-port behaviour and `mode`=1 selects output-port behaviour. A change of `mode` clears the register to 0x00 and returns `svc_req` to the new mode's idle level.
- R2: The port counts as selected when `sel_x`=1 and `sel_en`=1 in input mode, and when `sel_x`=0 and `sel_en`=1 in output mode.
- R3: In input mode, while `strobe` is high the register loads `din` on every system clock and `do_data` shows `din`. After `strobe` falls, the last byte is held.
- R4: In input mode, the falling edge of `strobe` asserts the request, driving `svc_req` low.
- R5: In input mode, `do_oe` is 1 only while the port is selected. With `strobe` low, `do_data` shows the held register.
- R6: In input mode, the end of a selection (a falling edge of the selected condition) releases the request, so `svc_req` returns high. A selection lasting a single system clock has this effect too.
- R7: In output mode, `do_oe` is always 1. The register loads `din` only while the port is selected and `strobe` is high. A strobe while deselected leaves the register unchanged.
- R8: In output mode, the end of a selection drives `svc_req` high. It stays high until the next falling edge of `strobe`, which drives it low.
- R9: `clr_n`=0 at once, without a clock, forces the register and `do_data` to 0x00 and `svc_req` to its idle level: 1 in input mode, 0 in output mode.
- R10: `strobe`, `sel_x` and `sel_en` each pass through a two-stage synchronizer. A rise of `strobe` that is driven between clock edges shows on `do_data` after the second following rising edge, not after the first.
- R11: When a strobe fall and a selection end are seen in the same clock, input mode leaves the request asserted (`svc_req`=0) and output mode leaves it asserted (`svc_req`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 1 | 0 = input port, 1 = output port |
| strobe | input | 1 | Data strobe (asynchronous) |
| sel_x | input | 1 | Select whose polarity follows the mode (asynchronous) |
| sel_en | input | 1 | Active-high select (asynchronous) |
| din | input | 8 | Data in |
| do_data | output | 8 | Data out value |
| do_oe | output | 1 | Data out drive enable |
| svc_req | output | 1 | Service request, level meaning set by mode |

## Verification
The bench goes after the following corner cases, each against an independent model of the pin-level rules:
- A select pulse only one clock long. A design that filters it out would leave the input-side request stuck asserted.
- A strobe fall and a deselect landing in the same clock. A design with the wrong priority in either mode would drop a pending request or raise a false one.
- A strobe while deselected in output mode. A design that ignored the select in its load condition would overwrite the output byte.
- Clear and mode changes in mid-traffic. Here the register must read zero and the request its mode-dependent idle level.
- The exact number of cycles through the synchronizer. A one-stage design would show data one cycle early.

// File: rtl/hbp_pkg.sv
`timescale 1ns/1ps
package hbp_pkg;

    typedef enum logic {
        PORT_IN  = 1'b0,
        PORT_OUT = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic req;        // request pending (active meaning set by mode)
        logic stb_prev;   // synchronized strobe, one clock late
        logic sel_prev;   // selected condition, one clock late
        logic mode_prev;  // mode seen last clock
    } port_ctl_t;

endpackage

// File: rtl/hbp_sync.sv
`timescale 1ns/1ps
module hbp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    assign chain_d[0] = d;

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            assign chain_d[g] = chain_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hbp_core.sv
`timescale 1ns/1ps
module hbp_core
    import hbp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              mode,
    input  logic              stb_s,
    input  logic              cs1_s,
    input  logic              cs2_s,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] do_data,
    output logic              do_oe,
    output logic              svc_req
);

    port_mode_e        mode_e;
    port_ctl_t         ctl_d, ctl_q;
    logic [DATA_W-1:0] data_d, data_q;
    logic              sel, load, stb_fall, sel_fall, mode_chg;

    always_comb begin
        mode_e   = port_mode_e'(mode);
        sel      = (mode_e == PORT_IN) ? (cs1_s & cs2_s) : (~cs1_s & cs2_s);
        load     = stb_s & ((mode_e == PORT_IN) | sel);
        stb_fall = ctl_q.stb_prev & ~stb_s;
        sel_fall = ctl_q.sel_prev & ~sel;
        mode_chg = (mode != ctl_q.mode_prev);

        data_d          = data_q;
        ctl_d           = ctl_q;
        ctl_d.stb_prev  = stb_s;
        ctl_d.sel_prev  = sel;
        ctl_d.mode_prev = mode;

        if (mode_chg) begin
            // a mode switch acts as a clear; edges across it are discarded
            data_d         = '0;
            ctl_d.req      = 1'b0;
            ctl_d.stb_prev = 1'b0;
            ctl_d.sel_prev = 1'b0;
        end else begin
            if (load) data_d = din;
            if (mode_e == PORT_IN) begin
                // new data beats the end of a read
                if (stb_fall)      ctl_d.req = 1'b1;
                else if (sel_fall) ctl_d.req = 1'b0;
            end else begin
                // the deselect beats the strobe trailing edge
                if (sel_fall)      ctl_d.req = 1'b1;
                else if (stb_fall) ctl_d.req = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            data_q <= '0;
            ctl_q  <= '0;
        end else begin
            data_q <= data_d;
            ctl_q  <= ctl_d;
        end
    end

    assign do_oe   = (mode_e == PORT_OUT) | sel;
    assign do_data = load ? din : data_q;
    assign svc_req = (mode_e == PORT_OUT) ? ctl_q.req : ~ctl_q.req;

    // R4: a strobe trailing edge in input mode pulls the request pin low
    assert_in_req_set_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_e == PORT_IN && !mode_chg && stb_fall) |=> !svc_req);

    // R6: end of a read releases the request unless new data arrived
    assert_in_req_release_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_e == PORT_IN && !mode_chg && sel_fall && !stb_fall) |=> (svc_req || mode != $past(mode)));

    // R8: deselect in output mode signals the peripheral
    assert_out_req_set_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_e == PORT_OUT && !mode_chg && sel_fall) |=> (svc_req || mode != $past(mode)));

    // R3, R7: without a qualified strobe the register holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && !mode_chg) |=> $stable(data_q));

    // R1: mode switch empties the register and the request
    assert_mode_clear_R1: assert property (@(posedge clk) disable iff (!clr_n)
        mode_chg |=> (data_q == '0 && !ctl_q.req));

endmodule

// File: rtl/hs_byte_port.sv
`timescale 1ns/1ps
module hs_byte_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              mode,
    input  logic              strobe,
    input  logic              sel_x,
    input  logic              sel_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] do_data,
    output logic              do_oe,
    output logic              svc_req
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_raw, pins_s;

    assign pins_raw = {strobe, sel_x, sel_en};

    hbp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    hbp_core #(.DATA_W(DATA_W)) i_core (
        .clk     (clk),
        .clr_n   (clr_n),
        .mode    (mode),
        .stb_s   (pins_s[2]),
        .cs1_s   (pins_s[1]),
        .cs2_s   (pins_s[0]),
        .din     (din),
        .do_data (do_data),
        .do_oe   (do_oe),
        .svc_req (svc_req)
    );

endmodule

// File: tb/test_hs_byte_port.sv
`timescale 1ns/1ps
module test_hs_byte_port;

    logic       clk = 1'b0;
    logic       clr_n, mode, strobe, sel_x, sel_en;
    logic [7:0] din;
    logic [7:0] do_data;
    logic       do_oe, svc_req;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // bench model state
    logic       mode_r, stb_r, c1_r, c2_r;
    logic [7:0] din_r, m_reg;
    logic       m_req;

    always #10 clk = ~clk;  // 50 MHz

    hs_byte_port i_hs_byte_port (
        .clk(clk), .clr_n(clr_n), .mode(mode), .strobe(strobe),
        .sel_x(sel_x), .sel_en(sel_en), .din(din),
        .do_data(do_data), .do_oe(do_oe), .svc_req(svc_req)
    );

    function automatic logic sel_of(logic m, logic a, logic b);
        return m ? (!a && b) : (a && b);
    endfunction

    function automatic logic load_of(logic m, logic s, logic a, logic b);
        return s && (!m || sel_of(m, a, b));
    endfunction

    function automatic logic exp_sr(logic m, logic rq);
        return m ? rq : !rq;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(mode_r ? "R7 oe" : "R5 oe", do_oe, mode_r | sel_of(mode_r, c1_r, c2_r));
        chk(mode_r ? "R7 data" : "R3 data", do_data, load_of(mode_r, stb_r, c1_r, c2_r) ? din_r : m_reg);
        chk(mode_r ? "R8 sr" : "R4 sr", svc_req, exp_sr(mode_r, m_req));
    endtask

    task automatic apply(input logic s, input logic a, input logic b, input logic [7:0] d_in);
        logic [7:0] d;
        logic os, ns, ol, nl, sf, slf;
        d  = d_in;
        os = sel_of(mode_r, c1_r, c2_r);
        ns = sel_of(mode_r, a, b);
        ol = load_of(mode_r, stb_r, c1_r, c2_r);
        nl = load_of(mode_r, s, a, b);
        if (ol && !nl) d = din_r;  // data held steady across a closing load window
        sf  = stb_r && !s;
        slf = os && !ns;
        @(negedge clk);
        strobe = s; sel_x = a; sel_en = b; din = d;
        stb_r = s; c1_r = a; c2_r = b; din_r = d;
        if (nl) m_reg = d;
        if (!mode_r) begin
            if (sf) m_req = 1'b1; else if (slf) m_req = 1'b0;
        end else begin
            if (slf) m_req = 1'b1; else if (sf) m_req = 1'b0;
        end
        repeat (5) @(negedge clk);
        check_all();
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode = m; mode_r = m;
        m_reg = 8'h00; m_req = 1'b0;
        if (load_of(mode_r, stb_r, c1_r, c2_r)) m_reg = din_r;
        repeat (5) @(negedge clk);
        chk("R1 data", do_data, load_of(mode_r, stb_r, c1_r, c2_r) ? din_r : 8'h00);
        chk("R1 sr", svc_req, exp_sr(mode_r, 1'b0));
        chk("R1 oe", do_oe, mode_r | sel_of(mode_r, c1_r, c2_r));
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_n = 1'b0;
        #2;
        chk("R9 data", do_data, 8'h00);
        chk("R9 sr", svc_req, exp_sr(mode_r, 1'b0));
        chk("R9 oe", do_oe, mode_r);
        m_reg = 8'h00; m_req = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        if (load_of(mode_r, stb_r, c1_r, c2_r)) m_reg = din_r;
        repeat (5) @(negedge clk);
        check_all();
    endtask

    task automatic rand_steps(input int n);
        for (int i = 0; i < n; i++) begin
            logic s, a, b;
            s = 1'($urandom % 2);
            a = 1'($urandom % 2);
            b = ($urandom % 4) != 0;
            apply(s, a, b, 8'($urandom));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        clr_n = 1'b0; mode = 1'b0; strobe = 1'b0; sel_x = 1'b0; sel_en = 1'b0; din = 8'h00;
        mode_r = 1'b0; stb_r = 1'b0; c1_r = 1'b0; c2_r = 1'b0; din_r = 8'h00;
        m_reg = 8'h00; m_req = 1'b0;
        #5;
        // R9: reset state, input mode
        chk("R9 reset data", do_data, 8'h00);
        chk("R9 reset sr", svc_req, 1'b1);
        chk("R9 reset oe", do_oe, 1'b0);
        @(negedge clk); clr_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: synchronizer latency on the strobe path
        @(negedge clk);
        strobe = 1'b1; din = 8'h5A; stb_r = 1'b1; din_r = 8'h5A; m_reg = 8'h5A;
        @(negedge clk);
        chk("R10 early", do_data, 8'h00);
        @(negedge clk);
        chk("R10 due", do_data, 8'h5A);
        repeat (4) @(negedge clk);

        // R3/R4: trailing edge holds the byte and asserts the request
        apply(1'b0, 1'b0, 1'b0, 8'h5A);
        chk("R4 asserted", svc_req, 1'b0);
        apply(1'b0, 1'b0, 1'b0, 8'hC3);  // din change with strobe low is ignored
        chk("R3 held", do_data, 8'h5A);

        // R2: wrong select polarity for input mode does not enable
        apply(1'b0, 1'b0, 1'b1, 8'hC3);
        chk("R2 in not selected", do_oe, 1'b0);
        apply(1'b0, 1'b1, 1'b1, 8'hC3);
        chk("R2 in selected", do_oe, 1'b1);
        chk("R5 read data", do_data, 8'h5A);
        apply(1'b0, 1'b0, 1'b1, 8'hC3);
        chk("R6 released", svc_req, 1'b1);

        // R6: one-clock selection still releases the request
        apply(1'b1, 1'b0, 1'b0, 8'h11);
        apply(1'b0, 1'b0, 1'b0, 8'h11);
        chk("R4 second", svc_req, 1'b0);
        @(negedge clk); sel_x = 1'b1; sel_en = 1'b1;
        @(negedge clk); sel_x = 1'b0; sel_en = 1'b0;
        m_req = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 short select", svc_req, 1'b1);

        // R11: input mode, strobe fall and deselect together keep request
        apply(1'b1, 1'b1, 1'b1, 8'h77);
        apply(1'b0, 1'b0, 1'b0, 8'h77);
        chk("R11 in", svc_req, 1'b0);

        rand_steps(150);

        // R1: switch to output mode
        apply(1'b0, 1'b0, 1'b0, 8'h00);
        apply(1'b1, 1'b0, 1'b0, 8'hA5);
        apply(1'b0, 1'b0, 1'b0, 8'hA5);
        set_mode(1'b1);

        // R2/R7: strobe while deselected is ignored
        apply(1'b0, 1'b1, 1'b1, 8'h3C);
        apply(1'b1, 1'b1, 1'b1, 8'h3C);
        chk("R7 ignored", do_data, 8'h00);
        chk("R7 oe", do_oe, 1'b1);
        apply(1'b0, 1'b1, 1'b1, 8'h3C);
        apply(1'b0, 1'b0, 1'b1, 8'h3C);
        apply(1'b1, 1'b0, 1'b1, 8'h3C);
        chk("R2 out write", do_data, 8'h3C);
        apply(1'b0, 1'b0, 1'b1, 8'h3C);
        chk("R7 held", do_data, 8'h3C);
        chk("R8 idle", svc_req, 1'b0);
        apply(1'b0, 1'b1, 1'b1, 8'h3C);
        chk("R8 raised", svc_req, 1'b1);
        apply(1'b1, 1'b1, 1'b1, 8'h3C);
        chk("R8 still high", svc_req, 1'b1);
        apply(1'b0, 1'b1, 1'b1, 8'h3C);
        chk("R8 dropped", svc_req, 1'b0);

        // R11: output mode, simultaneous strobe fall and deselect
        apply(1'b1, 1'b0, 1'b1, 8'h96);
        apply(1'b0, 1'b1, 1'b1, 8'h96);
        chk("R11 out", svc_req, 1'b1);

        rand_steps(150);

        // R9: clear in output mode
        apply(1'b0, 1'b0, 1'b1, 8'hE7);
        apply(1'b1, 1'b0, 1'b1, 8'hE7);
        apply(1'b0, 1'b1, 1'b1, 8'hE7);
        do_clear();

        // R1: back to input mode
        apply(1'b0, 1'b0, 1'b1, 8'h42);
        apply(1'b1, 1'b0, 1'b1, 8'h42);
        apply(1'b0, 1'b0, 1'b1, 8'h42);
        set_mode(1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule